// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Framing-Error Flag

This block is the receive half of a small microcontroller-style serial port. It watches an oversampled serial line and recovers frames that start with a low start bit. The data bits follow least-significant bit first, and the frame ends with a stop bit. One mode carries eight data bits. Two further modes carry a ninth data bit. Software sees the receiver through one 8-bit control register, which selects the mode, enables reception and holds the receive-complete and ninth-bit flags. The received byte is presented on its own output.

An optional framing check is switched on by a separate configuration input, which stands in for a bit kept in a different register. While the check is on, a stop bit sampled as 0 sets a framing-error flag. The flag stays set until software writes it to 0 or reset arrives. The top bit of the control register is shared. With the check off it is the upper mode-select bit. With the check on, the same position reads and writes the framing-error flag, and the stored mode bit is left alone. Turning the check on also moves the receive-complete flag from the last data bit to the stop bit.

The receiver takes a sample-rate tick, normally 16 ticks per bit. It confirms a start bit by a three-sample majority vote at mid-bit, and it keeps no link to any transmit logic.

Top module: `serial_rx_fe`

## Requirements
- R1: After reset, ctlRdData reads 0x00, rxData reads 0, and rxDone and frameErr are both 0.
- R2: Control register layout: bit 7 is the upper mode bit (or the error flag, see R8), bit 6 is the lower mode bit, bit 4 enables reception, bit 2 is the ninth/stop bit, bit 0 is the receive-complete flag, and bits 5, 3 and 1 read 0. Mode {bit7,bit6} = 01 receives 8 data bits LSB first and places them on rxData.
- R3: Modes 10 and 11 receive 9 data bits. The ninth bit goes to register bit 2 and to rxBit9, and the low eight bits go to rxData.
- R4: In mode 01, register bit 2 and rxBit9 take the value of the sampled stop bit of each accepted frame.
- R5: A low pulse on the line that has ended before the start-bit mid-point samples (fewer than half a bit) is a false start. No frame is received.
- R6: With cfgFeEn = 1, a frame whose stop bit samples 0 sets frameErr, and the frame is still delivered.
- R7: frameErr stays set across later frames that have a valid stop bit. It is cleared only by writing 0 to bit 7 while cfgFeEn = 1, or by reset.
- R8: With cfgFeEn = 0, bit 7 reads and writes the upper mode bit, and frameErr does not change. With cfgFeEn = 1, bit 7 reads and writes frameErr, and the stored upper mode bit keeps its value.
- R9: With cfgFeEn = 0, rxDone rises during the last data bit period (bit period 8 in mode 01, counting the start bit as period 0). With cfgFeEn = 1, it rises during the stop bit period (9 in mode 01, 10 in the 9-bit modes).
- R10: rxDone stays set until software writes bit 0 to 0. A frame that completes while rxDone is set is discarded, and rxData is left unchanged.
- R11: When bit 4 is 0, or the mode is 00, no frame is received.
- R12: With cfgFeEn = 0, a stop bit of 0 never sets frameErr, and the frame is delivered with the stop value in bit 2 in mode 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial line, idle high |
| sampleTick | input | 1 | Oversample tick, OVERSAMPLE ticks per bit |
| cfgFeEn | input | 1 | Framing-check enable from the separate config register |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 8 | Control register write value |
| ctlRdData | output | 8 | Control register read value |
| rxData | output | 8 | Last accepted data byte |
| rxBit9 | output | 1 | Ninth bit or stop bit (register bit 2) |
| rxDone | output | 1 | Receive-complete flag (register bit 0) |
| frameErr | output | 1 | Sticky framing-error flag |

## Verification
The bench measures which bit period rxDone rises in under each enable setting. A design that left the flag at the last data bit with the check on, or moved it to the stop bit with the check off, is reported by period number. It sends a bad stop bit followed by good frames, and a design that lets a good frame clear the error flag fails there. It also moves bit 7 between its two roles: after the error flag is cleared through bit 7, a 9-bit frame must still land its ninth bit, so a design that let the write reach the mode bit is caught. Short start glitches, frames that arrive while the flag is still set, and disabled reception check that the receiver stays idle or keeps the old byte when it should.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int RX_DATA_W = 8;
  localparam int RX_IDX_W  = $clog2(RX_DATA_W + 1);

  typedef struct packed {
    logic                shift;     // a data bit was decided this cycle
    logic [RX_IDX_W-1:0] idx;       // position of that data bit
    logic                bitVal;    // majority value of the decided bit
    logic                commit;    // frame completion point reached
    logic                stopCheck; // stop bit was decided this cycle
    logic                stopVal;   // majority value of the stop bit
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = RX_DATA_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  input  logic       sampleTick,
  input  logic       rxEnable,
  input  logic       nineBit,
  input  logic       cfgFeEn,
  output rxStrobe_t  strobe
);
  localparam int PH_W  = $clog2(OVERSAMPLE);
  localparam int SMP_B = OVERSAMPLE / 2;
  localparam int SMP_A = SMP_B - 1;
  localparam int SMP_C = SMP_B + 1;
  localparam int CNT_W = $clog2(DATA_W + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_e;

  rxState_e         state;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] bitNum;
  logic             syncA, rxSync;
  logic             smpFirst, smpSecond;
  logic             armed;
  logic             decide, vote, lastData;
  logic [CNT_W-1:0] lastIdx;

  // two-stage synchronizer on the asynchronous line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      syncA  <= rxIn;
      rxSync <= syncA;
    end
  end

  assign lastIdx  = nineBit ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  assign decide   = sampleTick && (state != ST_IDLE) && (phase == PH_W'(SMP_C));
  assign vote     = (smpFirst & smpSecond) | (smpFirst & rxSync) | (smpSecond & rxSync);
  assign lastData = (bitNum == lastIdx);

  always_comb begin
    strobe           = '0;
    strobe.idx       = RX_IDX_W'(bitNum);
    strobe.bitVal    = vote;
    strobe.stopVal   = vote;
    if (decide) begin
      unique case (state)
        ST_DATA: begin
          strobe.shift  = 1'b1;
          strobe.commit = lastData && !cfgFeEn;
        end
        ST_STOP: begin
          strobe.stopCheck = 1'b1;
          strobe.commit    = cfgFeEn;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= '0;
      bitNum    <= '0;
      smpFirst  <= 1'b1;
      smpSecond <= 1'b1;
      armed     <= 1'b0;
    end else if (sampleTick) begin
      if (state == ST_IDLE) begin
        phase <= '0;
        if (rxSync) begin
          armed <= 1'b1;
        end else if (armed && rxEnable) begin
          state <= ST_START;
          armed <= 1'b0;
        end
      end else begin
        phase <= (phase == PH_W'(OVERSAMPLE - 1)) ? '0 : phase + 1'b1;
        if (phase == PH_W'(SMP_A)) smpFirst  <= rxSync;
        if (phase == PH_W'(SMP_B)) smpSecond <= rxSync;
        if (decide) begin
          unique case (state)
            ST_START: begin
              bitNum <= '0;
              state  <= vote ? ST_IDLE : ST_DATA;
              armed  <= vote;
            end
            ST_DATA: begin
              if (lastData) state  <= ST_STOP;
              else          bitNum <= bitNum + 1'b1;
            end
            ST_STOP: begin
              state <= ST_IDLE;
              armed <= vote; // a low stop must see the line high again
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = RX_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgFeEn,
  input  logic              ctlWrEn,
  input  logic [7:0]        ctlWrData,
  input  rxStrobe_t         strobe,
  output logic              rxEnable,
  output logic              nineBit,
  output logic [7:0]        ctlRdData,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              frameErr
);
  logic              modeHi, modeLo, recvOn, bit9Reg, doneReg, errReg, acceptPend;
  logic [DATA_W:0]   frameBuf, merged;
  logic [DATA_W-1:0] dataReg;
  logic              acceptNow, unusedWrBits;

  assign unusedWrBits = ^{ctlWrData[5], ctlWrData[3], ctlWrData[1]};

  assign nineBit   = modeHi;
  assign rxEnable  = recvOn && (modeHi || modeLo);
  assign acceptNow = strobe.commit && !doneReg;

  always_comb begin
    merged = frameBuf;
    if (strobe.shift) merged[strobe.idx] = strobe.bitVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeHi     <= 1'b0;
      modeLo     <= 1'b0;
      recvOn     <= 1'b0;
      bit9Reg    <= 1'b0;
      doneReg    <= 1'b0;
      errReg     <= 1'b0;
      acceptPend <= 1'b0;
      frameBuf   <= '0;
      dataReg    <= '0;
    end else begin
      if (ctlWrEn) begin
        modeLo  <= ctlWrData[6];
        recvOn  <= ctlWrData[4];
        bit9Reg <= ctlWrData[2];
        doneReg <= ctlWrData[0];
        if (cfgFeEn) errReg <= ctlWrData[7];
        else         modeHi <= ctlWrData[7];
      end
      if (strobe.shift) frameBuf <= merged;
      if (acceptNow) begin
        dataReg    <= merged[DATA_W-1:0];
        doneReg    <= 1'b1;
        acceptPend <= !strobe.stopCheck;
        if (modeHi) bit9Reg <= merged[DATA_W];
      end
      if (strobe.stopCheck) begin
        if (!modeHi && (acceptPend || acceptNow)) bit9Reg <= strobe.stopVal;
        if (!acceptNow) acceptPend <= 1'b0;
        if (cfgFeEn && !strobe.stopVal) errReg <= 1'b1;
      end
    end
  end

  assign ctlRdData = {cfgFeEn ? errReg : modeHi, modeLo, 1'b0, recvOn,
                      1'b0, bit9Reg, 1'b0, doneReg};
  assign rxData    = dataReg;
  assign rxBit9    = bit9Reg;
  assign rxDone    = doneReg;
  assign frameErr  = errReg;
endmodule

// File: rtl/serial_rx_fe.sv
module serial_rx_fe
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  input  logic       sampleTick,
  input  logic       cfgFeEn,
  input  logic       ctlWrEn,
  input  logic [7:0] ctlWrData,
  output logic [7:0] ctlRdData,
  output logic [7:0] rxData,
  output logic       rxBit9,
  output logic       rxDone,
  output logic       frameErr
);
  rxStrobe_t strobe;
  logic      rxEnable, nineBit;

  serial_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(RX_DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .sampleTick(sampleTick),
    .rxEnable(rxEnable), .nineBit(nineBit), .cfgFeEn(cfgFeEn), .strobe(strobe)
  );

  serial_rx_datapath #(.DATA_W(RX_DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgFeEn(cfgFeEn), .ctlWrEn(ctlWrEn),
    .ctlWrData(ctlWrData), .strobe(strobe), .rxEnable(rxEnable),
    .nineBit(nineBit), .ctlRdData(ctlRdData), .rxData(rxData),
    .rxBit9(rxBit9), .rxDone(rxDone), .frameErr(frameErr)
  );
endmodule

// File: rtl/serial_rx_fe_checker.sv
module serial_rx_fe_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgFeEn,
  input logic       ctlWrEn,
  input logic [7:0] ctlRdData,
  input logic [7:0] rxData,
  input logic       rxBit9,
  input logic       rxDone,
  input logic       frameErr
);
  // R7: no hardware path clears the error flag
  a_r7_fe_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !(ctlWrEn && cfgFeEn)) |=> frameErr);

  // R8: with the check off the flag is frozen
  a_r8_fe_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !cfgFeEn |=> $stable(frameErr));

  // R10: receive-complete flag holds until written
  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !ctlWrEn) |=> rxDone);

  // R10: the byte only changes when a frame is accepted
  a_r10_data_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> $rose(rxDone));

  // R2: reserved bits read zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRdData[5] == 1'b0) && (ctlRdData[3] == 1'b0) && (ctlRdData[1] == 1'b0));

  // R3: ninth bit output matches its register view
  a_r3_bit9_view: assert property (@(posedge clk) disable iff (!rstN)
    rxBit9 == ctlRdData[2]);
endmodule

bind serial_rx_fe serial_rx_fe_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgFeEn(cfgFeEn), .ctlWrEn(ctlWrEn),
  .ctlRdData(ctlRdData), .rxData(rxData), .rxBit9(rxBit9),
  .rxDone(rxDone), .frameErr(frameErr)
);

// File: tb/serial_rx_fe_tb.sv
module serial_rx_fe_tb;
  localparam int OS = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       sampleTick = 1'b1;
  logic       cfgFeEn = 1'b0;
  logic       ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = '0;
  logic [7:0] ctlRdData, rxData;
  logic       rxBit9, rxDone, frameErr;

  int checks = 0, failures = 0;
  int cycCnt = 0, startCyc = 0, riCyc = -1;
  logic prevDone = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_rx_fe #(.OVERSAMPLE(OS)) u_dut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .sampleTick(sampleTick),
    .cfgFeEn(cfgFeEn), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .rxData(rxData), .rxBit9(rxBit9),
    .rxDone(rxDone), .frameErr(frameErr)
  );

  always @(posedge clk) cycCnt <= cycCnt + 1;
  always @(negedge clk) begin
    if (rxDone && !prevDone) riCyc = cycCnt;
    prevDone = rxDone;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrCtl(input logic [7:0] d);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = d;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  // sends start, nBits data bits LSB first, one stop bit, then idle
  task automatic sendFrame(input logic [8:0] d, input int nBits, input logic stopV);
    @(negedge clk);
    riCyc = -1;
    startCyc = cycCnt;
    rxIn = 1'b0;
    repeat (OS) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      rxIn = d[i];
      repeat (OS) @(negedge clk);
    end
    rxIn = stopV;
    repeat (OS) @(negedge clk);
    rxIn = 1'b1;
    repeat (3 * OS) @(negedge clk);
  endtask

  function automatic int riPeriod();
    return (riCyc < 0) ? -1 : (riCyc - startCyc) / OS;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ctl", ctlRdData, 8'h00);
    chk("R1 data", rxData, 0);
    chk("R1 done", rxDone, 0);
    chk("R1 err", frameErr, 0);
  endtask

  task automatic t_mode1();
    cfgFeEn = 1'b0;
    wrCtl(8'h50);                     // mode 01, receive on
    chk("R2 readback", ctlRdData, 8'h50);
    sendFrame(9'h0A5, 8, 1'b1);
    chk("R2 data", rxData, 8'hA5);
    chk("R2 done", rxDone, 1);
    chk("R4 stop bit", rxBit9, 1);
    chk("R9 period off", riPeriod(), 8);
  endtask

  task automatic t_mode1_fe_on();
    cfgFeEn = 1'b1;
    wrCtl(8'h50);
    sendFrame(9'h03C, 8, 1'b1);
    chk("R9 period on", riPeriod(), 9);
    chk("R2 data fe on", rxData, 8'h3C);
    chk("R6 no err good stop", frameErr, 0);
  endtask

  task automatic t_nine_bit();
    cfgFeEn = 1'b0;
    wrCtl(8'h90);                     // mode 10
    sendFrame(9'h13C, 9, 1'b1);
    chk("R3 data", rxData, 8'h3C);
    chk("R3 ninth", rxBit9, 1);
    chk("R9 period 9bit off", riPeriod(), 9);
    wrCtl(8'hD4);                     // mode 11, bit 2 preset to 1
    sendFrame(9'h0C3, 9, 1'b1);
    chk("R3 data mode3", rxData, 8'hC3);
    chk("R3 ninth zero", ctlRdData[2], 0);
    cfgFeEn = 1'b1;
    wrCtl(8'h50);                     // bit7 now error flag: mode stays 11
    sendFrame(9'h155, 9, 1'b1);
    chk("R9 period 9bit on", riPeriod(), 10);
    chk("R8 mode kept ninth", rxBit9, 1);
    chk("R8 mode kept data", rxData, 8'h55);
    cfgFeEn = 1'b0;
    @(negedge clk);
    chk("R8 upper mode bit", ctlRdData[7], 1);
  endtask

  task automatic t_false_start();
    cfgFeEn = 1'b0;
    wrCtl(8'h50);
    @(negedge clk);
    rxIn = 1'b0;
    repeat (4) @(negedge clk);
    rxIn = 1'b1;
    repeat (12 * OS) @(negedge clk);
    chk("R5 no frame", rxDone, 0);
    sendFrame(9'h081, 8, 1'b1);
    chk("R5 recovers", rxData, 8'h81);
  endtask

  task automatic t_fe_sticky();
    cfgFeEn = 1'b1;
    wrCtl(8'h50);
    sendFrame(9'h066, 8, 1'b0);
    chk("R6 err set", frameErr, 1);
    chk("R6 delivered", rxData, 8'h66);
    chk("R8 bit7 is err", ctlRdData[7], 1);
    wrCtl(8'hD0);                     // clear done, keep error (bit7=1)
    sendFrame(9'h011, 8, 1'b1);
    chk("R7 sticky good frame", frameErr, 1);
    wrCtl(8'hD0);
    sendFrame(9'h022, 8, 1'b1);
    chk("R7 sticky second", frameErr, 1);
    wrCtl(8'h50);                     // write 0 to bit7 with check on
    @(negedge clk);
    chk("R7 sw clear", frameErr, 0);
    cfgFeEn = 1'b0;
    @(negedge clk);
    chk("R8 mode bit unchanged", ctlRdData[7], 0);
  endtask

  task automatic t_alias_off();
    cfgFeEn = 1'b1;
    wrCtl(8'h50);
    sendFrame(9'h000, 8, 1'b0);       // set error flag
    cfgFeEn = 1'b0;
    wrCtl(8'h10);                     // bit7 -> mode bit, not flag
    @(negedge clk);
    chk("R8 off write keeps err", frameErr, 1);
    chk("R8 off read mode", ctlRdData[7], 0);
    cfgFeEn = 1'b1;
    wrCtl(8'h50);
    cfgFeEn = 1'b0;
  endtask

  task automatic t_discard();
    cfgFeEn = 1'b0;
    wrCtl(8'h50);
    sendFrame(9'h0F0, 8, 1'b1);
    sendFrame(9'h00F, 8, 1'b1);       // done still set
    chk("R10 done held", rxDone, 1);
    chk("R10 discarded", rxData, 8'hF0);
  endtask

  task automatic t_disabled();
    cfgFeEn = 1'b0;
    wrCtl(8'h40);                     // receive off
    sendFrame(9'h0AA, 8, 1'b1);
    chk("R11 ren off", rxDone, 0);
    wrCtl(8'h10);                     // mode 00
    sendFrame(9'h0AA, 8, 1'b1);
    chk("R11 mode00", rxDone, 0);
    chk("R11 data kept", rxData, 8'hF0);
  endtask

  task automatic t_stop_low_off();
    cfgFeEn = 1'b0;
    wrCtl(8'h54);                     // bit 2 preset 1
    sendFrame(9'h099, 8, 1'b0);
    chk("R12 no err", frameErr, 0);
    chk("R12 delivered", rxData, 8'h99);
    chk("R12 stop in bit2", rxBit9, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_mode1();
    t_mode1_fe_on();
    t_nine_bit();
    t_false_start();
    t_fe_sticky();
    t_alias_off();
    t_discard();
    t_disabled();
    t_stop_low_off();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule